// File: doc/BRIEF.md
# Multiplexed-Bus SDRAM Access Sequencer

This block performs single read and write accesses to a 16-bit SDRAM whose row address, column address and data all travel over one shared bus. A host presents a request (direction, row, column, halfword count) for one cycle while the block is idle. The block then issues the row-open command, waits out the fixed CAS latency of 2, issues the column command and moves the data beats. It closes the access with a deselect cycle that also serves as the mandatory gap before the next access. Write data is taken from the host combinationally in each cycle where `wr_ready` is high. Read data is returned registered, with one `rd_valid` strobe per halfword. `done` pulses in the closing cycle.

The state machine has ten named states. IDLE waits for a request. ACT issues Activate with the row. GAP is a NOP that still drives the row. RCMD issues Read with the column. RTURN is a NOP in which the bus is released. RDATA captures one halfword per cycle. WCMD issues Write at column minus one with both byte masks set. WDATA drives one halfword per cycle with the masks clear. WTERM issues Burst Terminate. END deselects the device and pulses `done`.

The transitions are as follows. IDLE goes to ACT when `req_valid` is high. ACT goes to GAP. GAP goes to WCMD or RCMD, depending on the latched direction. RCMD goes to RTURN, and RTURN goes to RDATA. RDATA goes to END after its last beat. WCMD goes to WDATA. WDATA goes to WTERM after its last beat. WTERM goes to END, and END goes to IDLE.

Top module: `sdram_seq`

## Requirements
- R1: After reset, and in every idle cycle, the block shows `busy`=0, `done`=0, `rd_valid`=0, `wr_ready`=0 and `ad_oe`=0. It also shows `sd_dqm`=2'b11 and the deselect command. The command is written as the vector {`sd_csn`,`sd_rasn`,`sd_casn`,`sd_wen`}, and deselect is 4'b1111.
- R2: A request is accepted only at a clock edge where the block is idle and `req_valid` is high. `busy` is high from the cycle after acceptance through the END cycle. Requests presented while busy have no effect.
- R3: Counting from the cycle after acceptance as cycle 0, cycle 0 carries Activate (4'b0011) with the row on `ad_out`. Cycle 1 carries NOP (4'b0111) with the row still driven. In both cycles `ad_oe`=1 and `sd_dqm`=2'b11.
- R4: Cycle 2 carries the column command with `ad_oe`=1. For a read this is Read (4'b0101) with the column on the bus. For a write this is Write (4'b0100) with (column − 1) mod 2^16 on the bus.
- R5: A read transfers 2 halfwords when the count is 2 or more, and 1 halfword otherwise. Cycle 3 is a NOP with `ad_oe`=0. The data cycles 4 … 3+n are NOPs with `ad_oe`=0. `sd_dqm` is 2'b00 from cycle 2 through cycle 3+n.
- R6: The value on `ad_in` in each read data cycle is presented on `rd_data`, with `rd_valid`=1, in the following cycle. `rd_valid` is 0 in every other cycle.
- R7: In the Write command cycle, `sd_dqm`=2'b11. A write transfers n = count halfwords, and a count of 0 is treated as 1. Cycles 3 … 2+n are NOPs with `sd_dqm`=2'b00, `ad_oe`=1, `wr_ready`=1 and `ad_out` equal to `wr_data`.
- R8: Cycle 3+n of a write carries Burst Terminate (4'b0110) with `sd_dqm`=2'b11 and `ad_oe`=0.
- R9: Cycle 4+n of either access is the END cycle. It carries deselect (4'b1111) with `ad_oe`=0, `sd_dqm`=2'b11, `busy`=1 and a one-cycle `done`=1. The following cycle is idle, and a request presented in it is accepted.
- R10: `sd_cke` is 1 in every cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the SDRAM clock domain |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, sampled when idle |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_row | input | 16 | Row address |
| req_col | input | 16 | Column address of the first halfword |
| req_count | input | CNT_W | Halfword count |
| wr_data | input | 16 | Write halfword, consumed when `wr_ready` is high |
| wr_ready | output | 1 | The current cycle drives `wr_data` onto the bus |
| rd_data | output | 16 | Captured read halfword |
| rd_valid | output | 1 | `rd_data` holds a new halfword |
| done | output | 1 | One-cycle pulse in the closing cycle |
| busy | output | 1 | Access in progress, including the closing gap |
| sd_cke | output | 1 | Clock enable |
| sd_csn | output | 1 | Chip select, active low |
| sd_rasn | output | 1 | Row strobe, active low |
| sd_casn | output | 1 | Column strobe, active low |
| sd_wen | output | 1 | Write enable, active low |
| sd_dqm | output | 2 | Byte masks {high, low}, 1 = masked |
| ad_out | output | 16 | Shared address/data bus, outbound value |
| ad_oe | output | 1 | Drive enable for `ad_out` |
| ad_in | input | 16 | Shared address/data bus, inbound value |

## Verification
Every result is due at a fixed cycle offset from the accepting edge. The bench drives inputs at the falling edge and counts cycles from the one after acceptance. For a count of n, each cycle from 0 through 5+n has a known command, bus value, mask and strobe state. The bench samples these just after the falling edge and compares them with values computed from the cycle index and n. Read data is due one cycle after its bus cycle, so the bench keeps the `ad_in` value it drove in the previous cycle and compares `rd_data` against it. Write data is compared combinationally in the same cycle. Each access is preceded by exactly one idle cycle, which exercises the minimum gap.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ACT,
        ST_GAP,
        ST_RCMD,
        ST_RTURN,
        ST_RDATA,
        ST_WCMD,
        ST_WDATA,
        ST_WTERM,
        ST_END
    } seq_state_t;

    // {csn, rasn, casn, wen}, all active low
    localparam logic [3:0] CMD_ACT   = 4'b0011;
    localparam logic [3:0] CMD_READ  = 4'b0101;
    localparam logic [3:0] CMD_WRITE = 4'b0100;
    localparam logic [3:0] CMD_BTERM = 4'b0110;
    localparam logic [3:0] CMD_NOP   = 4'b0111;
    localparam logic [3:0] CMD_DESEL = 4'b1111;

endpackage

// File: rtl/sdram_seq_fsm.sv
module sdram_seq_fsm
    import sdram_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       is_write,
    input  logic       last_beat,
    output seq_state_t state
);

    seq_state_t state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (req_valid) state_nx = ST_ACT;
            ST_ACT:   state_nx = ST_GAP;
            ST_GAP:   state_nx = is_write ? ST_WCMD : ST_RCMD;
            ST_RCMD:  state_nx = ST_RTURN;
            ST_RTURN: state_nx = ST_RDATA;
            ST_RDATA: if (last_beat) state_nx = ST_END;
            ST_WCMD:  state_nx = ST_WDATA;
            ST_WDATA: if (last_beat) state_nx = ST_WTERM;
            ST_WTERM: state_nx = ST_END;
            ST_END:   state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/sdram_seq_beats.sv
module sdram_seq_beats #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             last
);

    logic [CNT_W-1:0] left;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    left <= '0;
        else if (load) left <= load_val;
        else if (dec)  left <= left - 1'b1;
    end

    assign last = (left <= CNT_W'(1));

endmodule

// File: rtl/sdram_seq_rdcap.sv
module sdram_seq_rdcap #(
    parameter int BUS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample,
    input  logic [BUS_W-1:0] bus_in,
    output logic [BUS_W-1:0] data,
    output logic             valid
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data  <= '0;
            valid <= 1'b0;
        end else begin
            valid <= sample;
            if (sample) data <= bus_in;
        end
    end

endmodule

// File: rtl/sdram_seq.sv
module sdram_seq
    import sdram_seq_pkg::*;
#(
    parameter int BUS_W = 16,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [BUS_W-1:0] req_row,
    input  logic [BUS_W-1:0] req_col,
    input  logic [CNT_W-1:0] req_count,
    input  logic [BUS_W-1:0] wr_data,
    output logic             wr_ready,
    output logic [BUS_W-1:0] rd_data,
    output logic             rd_valid,
    output logic             done,
    output logic             busy,
    output logic             sd_cke,
    output logic             sd_csn,
    output logic             sd_rasn,
    output logic             sd_casn,
    output logic             sd_wen,
    output logic [1:0]       sd_dqm,
    output logic [BUS_W-1:0] ad_out,
    output logic             ad_oe,
    input  logic [BUS_W-1:0] ad_in
);

    localparam int          RD_MAX   = 2;
    localparam logic [1:0]  DQM_OFF  = 2'b11;
    localparam logic [1:0]  DQM_ON   = 2'b00;

    seq_state_t       state;
    logic             accept;
    logic             write_q;
    logic [BUS_W-1:0] row_q;
    logic [BUS_W-1:0] col_q;
    logic [CNT_W-1:0] beats;
    logic             last_beat;
    logic [3:0]       cmd;

    assign accept = (state == ST_IDLE) && req_valid;

    always_comb begin
        if (req_write)
            beats = (req_count == '0) ? CNT_W'(1) : req_count;
        else
            beats = (req_count >= CNT_W'(RD_MAX)) ? CNT_W'(RD_MAX) : CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            write_q <= 1'b0;
            row_q   <= '0;
            col_q   <= '0;
        end else if (accept) begin
            write_q <= req_write;
            row_q   <= req_row;
            col_q   <= req_col;
        end
    end

    sdram_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .is_write  (write_q),
        .last_beat (last_beat),
        .state     (state)
    );

    sdram_seq_beats #(.CNT_W(CNT_W)) u_beats (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (beats),
        .dec      ((state == ST_RDATA) || (state == ST_WDATA)),
        .last     (last_beat)
    );

    sdram_seq_rdcap #(.BUS_W(BUS_W)) u_rdcap (
        .clk    (clk),
        .rst_n  (rst_n),
        .sample (state == ST_RDATA),
        .bus_in (ad_in),
        .data   (rd_data),
        .valid  (rd_valid)
    );

    // Output decode
    always_comb begin
        cmd      = CMD_NOP;
        sd_dqm   = DQM_OFF;
        ad_out   = '0;
        ad_oe    = 1'b0;
        wr_ready = 1'b0;
        done     = 1'b0;
        busy     = 1'b1;
        unique case (state)
            ST_IDLE: begin
                cmd  = CMD_DESEL;
                busy = 1'b0;
            end
            ST_ACT: begin
                cmd    = CMD_ACT;
                ad_out = row_q;
                ad_oe  = 1'b1;
            end
            ST_GAP: begin
                ad_out = row_q;
                ad_oe  = 1'b1;
            end
            ST_RCMD: begin
                cmd    = CMD_READ;
                ad_out = col_q;
                ad_oe  = 1'b1;
                sd_dqm = DQM_ON;
            end
            ST_RTURN, ST_RDATA: begin
                sd_dqm = DQM_ON;
            end
            ST_WCMD: begin
                cmd    = CMD_WRITE;
                ad_out = col_q - 1'b1;
                ad_oe  = 1'b1;
            end
            ST_WDATA: begin
                ad_out   = wr_data;
                ad_oe    = 1'b1;
                sd_dqm   = DQM_ON;
                wr_ready = 1'b1;
            end
            ST_WTERM: begin
                cmd = CMD_BTERM;
            end
            ST_END: begin
                cmd  = CMD_DESEL;
                done = 1'b1;
            end
            default: begin
                cmd  = CMD_DESEL;
                busy = 1'b0;
            end
        endcase
    end

    assign sd_cke = 1'b1;
    assign {sd_csn, sd_rasn, sd_casn, sd_wen} = cmd;

endmodule

// File: rtl/sdram_seq_checker.sv
module sdram_seq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       sd_cke,
    input logic       sd_csn,
    input logic       sd_rasn,
    input logic       sd_casn,
    input logic       sd_wen,
    input logic [1:0] sd_dqm,
    input logic       ad_oe,
    input logic       wr_ready,
    input logic       rd_valid,
    input logic       done,
    input logic       busy
);

    logic [3:0] cmd;
    assign cmd = {sd_csn, sd_rasn, sd_casn, sd_wen};

    p_cke_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sd_cke);

    p_busy_starts_act_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> cmd == 4'b0011);

    p_act_then_nop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == 4'b0011 |=> (cmd == 4'b0111 && ad_oe));

    p_col_two_after_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == 4'b0011 |-> ##2 (cmd == 4'b0101 || cmd == 4'b0100));

    p_read_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == 4'b0101 |=> !ad_oe);

    p_rdv_bus_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(!ad_oe));

    p_wcmd_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == 4'b0100 |-> sd_dqm == 2'b11);

    p_wcmd_then_beat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == 4'b0100 |=> (sd_dqm == 2'b00 && wr_ready));

    p_bterm_after_beat_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == 4'b0110 |-> ($past(wr_ready) && !ad_oe && sd_dqm == 2'b11));

    p_end_deselect_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cmd == 4'b1111 && !ad_oe && busy));

    p_end_then_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!busy && !done));

endmodule

bind sdram_seq sdram_seq_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sd_cke   (sd_cke),
    .sd_csn   (sd_csn),
    .sd_rasn  (sd_rasn),
    .sd_casn  (sd_casn),
    .sd_wen   (sd_wen),
    .sd_dqm   (sd_dqm),
    .ad_oe    (ad_oe),
    .wr_ready (wr_ready),
    .rd_valid (rd_valid),
    .done     (done),
    .busy     (busy)
);

// File: tb/sdram_seq_test.sv
module sdram_seq_test;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_write = 1'b0;
    logic [15:0]      req_row = '0;
    logic [15:0]      req_col = '0;
    logic [CNT_W-1:0] req_count = '0;
    logic [15:0]      wr_data = '0;
    logic [15:0]      ad_in = '0;
    logic             wr_ready, rd_valid, done, busy;
    logic             sd_cke, sd_csn, sd_rasn, sd_casn, sd_wen, ad_oe;
    logic [1:0]       sd_dqm;
    logic [15:0]      rd_data, ad_out;

    int vectors = 0;
    int miscompares = 0;

    sdram_seq #(.BUS_W(16), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_row(req_row), .req_col(req_col), .req_count(req_count),
        .wr_data(wr_data), .wr_ready(wr_ready), .rd_data(rd_data),
        .rd_valid(rd_valid), .done(done), .busy(busy), .sd_cke(sd_cke),
        .sd_csn(sd_csn), .sd_rasn(sd_rasn), .sd_casn(sd_casn), .sd_wen(sd_wen),
        .sd_dqm(sd_dqm), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: got %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [3:0] cur_cmd();
        return {sd_csn, sd_rasn, sd_casn, sd_wen};
    endfunction

    function automatic logic [15:0] bus_pat(input int i, input int n);
        return 16'h5A00 + 16'(i * 37) + 16'(n);
    endfunction

    function automatic logic [15:0] wd_pat(input int i);
        return 16'hC300 ^ 16'(i * 11);
    endfunction

    task automatic check_idle(input string req);
        chk({req, " busy"}, 32'(busy), 0);
        chk({req, " cmd"}, 32'(cur_cmd()), 32'hF);
        chk({req, " oe"}, 32'(ad_oe), 0);
        chk({req, " dqm"}, 32'(sd_dqm), 3);
        chk({req, " done"}, 32'(done), 0);
        chk({req, " wr_ready"}, 32'(wr_ready), 0);
        chk({req, " rd_valid"}, 32'(rd_valid), 0);
    endtask

    // Present a request in an idle cycle, then check cycles 0 .. 4+n.
    task automatic access(input bit wr, input logic [15:0] row, input logic [15:0] col,
                          input int cnt, input bit hold);
        int n;
        int endi;
        logic [15:0] prev_in;
        if (wr) n = (cnt == 0) ? 1 : cnt;
        else    n = (cnt >= 2) ? 2 : 1;
        endi = 4 + n;
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_row   = row;
        req_col   = col;
        req_count = CNT_W'(cnt);
        #1;
        check_idle("R9 idle gap / R1");
        prev_in = '0;
        for (int i = 0; i <= endi; i++) begin
            logic [3:0]  e_cmd;
            logic        e_oe;
            logic [15:0] e_ad;
            logic [1:0]  e_dqm;
            logic        e_wrr;
            @(negedge clk);
            req_valid = hold;
            if (hold) begin
                req_write = ~wr;
                req_row   = ~row;
                req_col   = ~col;
            end
            wr_data = wd_pat(i);
            ad_in   = bus_pat(i, n);
            #1;
            e_cmd = 4'b0111; e_oe = 1'b0; e_ad = '0; e_dqm = 2'b11; e_wrr = 1'b0;
            if (i == 0) begin e_cmd = 4'b0011; e_oe = 1'b1; e_ad = row; end
            else if (i == 1) begin e_oe = 1'b1; e_ad = row; end
            else if (i == 2) begin
                e_oe = 1'b1;
                if (wr) begin e_cmd = 4'b0100; e_ad = col - 16'd1; end
                else begin e_cmd = 4'b0101; e_ad = col; e_dqm = 2'b00; end
            end else if (i == endi) e_cmd = 4'b1111;
            else if (wr) begin
                if (i <= 2 + n) begin
                    e_oe = 1'b1; e_ad = wr_data; e_dqm = 2'b00; e_wrr = 1'b1;
                end else e_cmd = 4'b0110;
            end else e_dqm = 2'b00;

            chk(wr ? "R4/R7/R8 cmd" : "R3/R4/R5 cmd", 32'(cur_cmd()), 32'(e_cmd));
            chk("R3/R5/R8 ad_oe", 32'(ad_oe), 32'(e_oe));
            if (e_oe) chk(wr ? "R4/R7 ad_out" : "R3/R4 ad_out", 32'(ad_out), 32'(e_ad));
            chk("R5/R7/R8 dqm", 32'(sd_dqm), 32'(e_dqm));
            chk("R7 wr_ready", 32'(wr_ready), 32'(e_wrr));
            chk("R2 busy", 32'(busy), 1);
            chk("R9 done", 32'(done), 32'(i == endi));
            chk("R10 cke", 32'(sd_cke), 1);
            if (!wr && i >= 5 && i <= 4 + n) begin
                chk("R6 rd_valid", 32'(rd_valid), 1);
                chk("R6 rd_data", 32'(rd_data), 32'(prev_in));
            end else chk("R6 rd_valid", 32'(rd_valid), 0);
            prev_in = ad_in;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check_idle("R1 reset");
        chk("R10 cke reset", 32'(sd_cke), 1);
        // R5: reads with counts 0..4 (beats clamp to 1 or 2)
        for (int c = 0; c <= 4; c++)
            access(1'b0, 16'h1200 + 16'(c), 16'h0040 + 16'(c * 3), c, 1'b0);
        // R4/R7: writes with counts 0..6, including column wrap at 0
        for (int c = 0; c <= 6; c++)
            access(1'b1, 16'hA000 ^ 16'(c), (c == 2) ? 16'h0000 : 16'h0100 + 16'(c), c, 1'b0);
        access(1'b1, 16'hFFFF, 16'hFFFF, 1, 1'b0);
        access(1'b0, 16'h0000, 16'hFFFF, 2, 1'b0);
        // R2: requests held during busy are ignored
        access(1'b0, 16'h3C3C, 16'h0011, 2, 1'b1);
        access(1'b1, 16'h4B4B, 16'h0022, 3, 1'b1);
        access(1'b1, 16'h7777, 16'h0001, 2, 1'b0);
        // final idle cycle
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        check_idle("R9 idle after END / R1");
        @(negedge clk);
        #1;
        check_idle("R2 no stray accept");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule